// File: doc/BRIEF.md
# Linked-List Command Chain Walker

This block follows a chain of command blocks held in system memory and streams their payload words to a downstream command consumer. A walk begins with a one-cycle start pulse carrying a 24-bit address. Each node is a header word followed directly by its payload. The header's low 24 bits give the address of the next node, and its top 8 bits give how many payload words follow. The walk stops when the working address has bit 23 set.

Memory addresses are byte addresses. Only bits 20:2 select a 32-bit word, so the memory port carries a 19-bit word index. A corrupt list could cycle forever. To guard against this, once a parameterised number of nodes has been walked, the block sets bit 23 in the header of each further node it visits. A node that is reached a second time then ends the walk. Before it reports completion, the block goes back over the marked nodes, starting at the first one marked, and restores their headers. It also accumulates a cost of a fixed 5 per node plus the payload length, and presents the total when it finishes.

Top module: `dma_list_walker`

## Requirements
- R1: After reset, `busy`, `done`, `memReq` and `outValid` are low; while `busy` is low no memory request or output word is issued.
- R2: On a start pulse while idle, the working address is `startAddr`. If its bit 23 is set, the walk finishes with no memory access, no output word and a cost of 0.
- R3: A node header is read at word index = working address bits 20:2; bits 22:21 and 1:0 of the address are ignored. The next address is header bits 23:0 and the payload length is header bits 31:24.
- R4: The payload words sit at the consecutive word indices after the header. They are presented on `outData` in that order. `outValid` and `outData` hold until `outReady` accepts the word.
- R5: Nodes keep being visited until a next address with bit 23 set is loaded.
- R6: `costTotal` equals the sum over visited nodes of 5 plus the payload length. It is valid when `done` pulses and holds until the next accepted start.
- R7: Every node visited at zero-based index LOOP_THRESH or later whose header bit 23 is clear gets its header rewritten with bit 23 set. The rewrite happens before its payload is fetched.
- R8: A node revisited after being marked has its payload forwarded once more, and the walk then ends.
- R9: Before `done`, every header marked under R7 is rewritten with bit 23 cleared, walking from the first marked node. Memory is then identical to its state before the start.
- R10: A start pulse while `busy` is high is ignored.
- R11: A memory request holds its address, write enable and write data until `memReady` accepts it. A read has its data returned by `memRvalid` before the next request is issued.
- R12: `done` is a single-cycle pulse during the last busy cycle, and `busy` is low in the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | Start pulse, taken only while idle |
| startAddr | input | 24 | Byte address of the first node |
| memReq | output | 1 | Memory request valid |
| memWe | output | 1 | Request is a write |
| memAddr | output | 19 | Word index of the access |
| memWdata | output | 32 | Write data |
| memReady | input | 1 | Memory accepts the request this cycle |
| memRvalid | input | 1 | Read data valid |
| memRdata | input | 32 | Read data |
| outValid | output | 1 | Payload word valid |
| outData | output | 32 | Payload word |
| outReady | input | 1 | Consumer accepts the payload word |
| busy | output | 1 | Walk in progress |
| done | output | 1 | Walk complete pulse |
| costTotal | output | 32 | Accumulated cost of the walk |

## Verification
The assertions assume a memory that answers an accepted read with exactly one `memRvalid` pulse and never raises `memRvalid` unprompted. They also assume start pulses last one cycle. The bench memory model returns data in the cycle after acceptance. It throttles `memReady` and `outReady` at random and drives `start` for a single cycle only. Lists are generated with headers spaced widely enough that payload words never overlap another node. The loop threshold is lowered so that marking, revisits and restoration are reached quickly.

// File: rtl/dma_list_walker_pkg.sv
package dma_list_walker_pkg;

  typedef enum logic [3:0] {
    stIdle, stNext, stHdrRd, stHdrWait, stMark, stPayRd, stPayWait,
    stPayOut, stClrRd, stClrWait, stClrWr, stFin
  } walkState_t;

  typedef enum logic [1:0] {selHdr, selPay, selNode, selClr} addrSel_t;

  typedef struct packed {
    logic     ldStart;
    logic     ldHdr;
    logic     noteMark;
    logic     ldOut;
    logic     ldClrStart;
    logic     ldClrHdr;
    logic     clrNext;
    logic     wrSet;
    addrSel_t addrSel;
  } walkCtl_t;

endpackage

// File: rtl/dma_list_walker_dp.sv
module dma_list_walker_dp
  import dma_list_walker_pkg::*;
#(
  parameter int ADDR_W      = 24,
  parameter int MEM_AW      = 21,
  parameter int DATA_W      = 32,
  parameter int LEN_W       = 8,
  parameter int COST_W      = 32,
  parameter int NODE_COST   = 5,
  parameter int LOOP_THRESH = 8192
) (
  input  logic                clk,
  input  logic                rstN,
  input  walkCtl_t            ctl,
  input  logic [ADDR_W-1:0]   startAddr,
  input  logic [DATA_W-1:0]   memRdata,
  output logic [MEM_AW-3:0]   memAddr,
  output logic [DATA_W-1:0]   memWdata,
  output logic [DATA_W-1:0]   outData,
  output logic [COST_W-1:0]   costTotal,
  output logic                termNext,
  output logic                lenZero,
  output logic                markPend,
  output logic                haveMarks,
  output logic                clrDone
);

  localparam int TERM_BIT = ADDR_W - 1;
  localparam int WORD_AW  = MEM_AW - 2;
  localparam int CNT_W    = $clog2(LOOP_THRESH + 1);
  localparam int MARK_W   = WORD_AW + 1;
  localparam logic [CNT_W-1:0] THR = CNT_W'(LOOP_THRESH);

  logic [ADDR_W-1:0]  walkAddr;
  logic [WORD_AW-1:0] nodePtr, payPtr, firstMark, clrPtr;
  logic [LEN_W-1:0]   remLen;
  logic [CNT_W-1:0]   nodeCnt;
  logic [MARK_W-1:0]  markCnt, clrLeft;
  logic [COST_W-1:0]  costAcc;
  logic [DATA_W-1:0]  hdrWord, outWord;
  logic               pastThresh;

  assign pastThresh = (nodeCnt == THR);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      walkAddr  <= '0;
      nodePtr   <= '0;
      payPtr    <= '0;
      firstMark <= '0;
      clrPtr    <= '0;
      remLen    <= '0;
      nodeCnt   <= '0;
      markCnt   <= '0;
      clrLeft   <= '0;
      costAcc   <= '0;
      hdrWord   <= '0;
      outWord   <= '0;
      markPend  <= 1'b0;
    end else begin
      if (ctl.ldStart) begin
        walkAddr <= startAddr;
        nodeCnt  <= '0;
        markCnt  <= '0;
        costAcc  <= '0;
      end
      if (ctl.ldHdr) begin
        hdrWord  <= memRdata;
        nodePtr  <= walkAddr[MEM_AW-1:2];
        payPtr   <= walkAddr[MEM_AW-1:2] + WORD_AW'(1);
        walkAddr <= memRdata[ADDR_W-1:0];
        remLen   <= memRdata[DATA_W-1 -: LEN_W];
        costAcc  <= costAcc + COST_W'(NODE_COST) + COST_W'(memRdata[DATA_W-1 -: LEN_W]);
        markPend <= pastThresh && !memRdata[TERM_BIT];
        if (!pastThresh) nodeCnt <= nodeCnt + CNT_W'(1);
      end
      if (ctl.noteMark) begin
        if (markCnt == '0) firstMark <= nodePtr;
        markCnt <= markCnt + MARK_W'(1);
      end
      if (ctl.ldOut) begin
        outWord <= memRdata;
        payPtr  <= payPtr + WORD_AW'(1);
        remLen  <= remLen - LEN_W'(1);
      end
      if (ctl.ldClrStart) begin
        clrPtr  <= firstMark;
        clrLeft <= markCnt;
      end
      if (ctl.ldClrHdr) hdrWord <= memRdata;
      if (ctl.clrNext) begin
        clrPtr  <= hdrWord[MEM_AW-1:2];
        clrLeft <= clrLeft - MARK_W'(1);
      end
    end
  end

  always_comb begin
    unique case (ctl.addrSel)
      selHdr:  memAddr = walkAddr[MEM_AW-1:2];
      selPay:  memAddr = payPtr;
      selNode: memAddr = nodePtr;
      default: memAddr = clrPtr;
    endcase
  end

  assign memWdata  = {hdrWord[DATA_W-1:TERM_BIT+1], ctl.wrSet, hdrWord[TERM_BIT-1:0]};
  assign outData   = outWord;
  assign costTotal = costAcc;
  assign termNext  = walkAddr[TERM_BIT];
  assign lenZero   = (remLen == '0);
  assign haveMarks = (markCnt != '0);
  assign clrDone   = (clrLeft == '0);

  logic unusedAddrBits;
  assign unusedAddrBits = ^{walkAddr[1:0], walkAddr[TERM_BIT-1:MEM_AW]};

  // R7: a mark is only recorded for a node flagged past the threshold
  assert_mark_flagged_R7: assert property (@(posedge clk) disable iff (!rstN)
    ctl.noteMark |-> markPend);

  // R9: the restore pass never steps beyond the recorded marks
  assert_clr_bounded_R9: assert property (@(posedge clk) disable iff (!rstN)
    ctl.clrNext |-> !clrDone);

endmodule

// File: rtl/dma_list_walker_ctrl.sv
module dma_list_walker_ctrl
  import dma_list_walker_pkg::*;
(
  input  logic     clk,
  input  logic     rstN,
  input  logic     start,
  input  logic     memReady,
  input  logic     memRvalid,
  input  logic     outReady,
  input  logic     termNext,
  input  logic     lenZero,
  input  logic     markPend,
  input  logic     haveMarks,
  input  logic     clrDone,
  output walkCtl_t ctl,
  output logic     memReq,
  output logic     memWe,
  output logic     outValid,
  output logic     busy,
  output logic     done
);

  walkState_t state, nxt;

  always_ff @(posedge clk) begin
    if (!rstN) state <= stIdle;
    else       state <= nxt;
  end

  always_comb begin
    nxt    = state;
    ctl    = '0;
    memReq = 1'b0;
    memWe  = 1'b0;
    unique case (state)
      stIdle: if (start) begin
        ctl.ldStart = 1'b1;
        nxt = stNext;
      end
      stNext: begin
        if (!termNext) nxt = stHdrRd;
        else if (haveMarks) begin
          ctl.ldClrStart = 1'b1;
          nxt = stClrRd;
        end else nxt = stFin;
      end
      stHdrRd: begin
        memReq = 1'b1;
        ctl.addrSel = selHdr;
        if (memReady) nxt = stHdrWait;
      end
      stHdrWait: if (memRvalid) begin
        ctl.ldHdr = 1'b1;
        nxt = stMark;
      end
      stMark: begin
        ctl.addrSel = selNode;
        ctl.wrSet = 1'b1;
        if (!markPend) nxt = stPayRd;
        else begin
          memReq = 1'b1;
          memWe = 1'b1;
          if (memReady) begin
            ctl.noteMark = 1'b1;
            nxt = stPayRd;
          end
        end
      end
      stPayRd: begin
        ctl.addrSel = selPay;
        if (lenZero) nxt = stNext;
        else begin
          memReq = 1'b1;
          if (memReady) nxt = stPayWait;
        end
      end
      stPayWait: if (memRvalid) begin
        ctl.ldOut = 1'b1;
        nxt = stPayOut;
      end
      stPayOut: if (outReady) nxt = stPayRd;
      stClrRd: begin
        ctl.addrSel = selClr;
        if (clrDone) nxt = stFin;
        else begin
          memReq = 1'b1;
          if (memReady) nxt = stClrWait;
        end
      end
      stClrWait: begin
        ctl.addrSel = selClr;
        if (memRvalid) begin
          ctl.ldClrHdr = 1'b1;
          nxt = stClrWr;
        end
      end
      stClrWr: begin
        ctl.addrSel = selClr;
        memReq = 1'b1;
        memWe = 1'b1;
        if (memReady) begin
          ctl.clrNext = 1'b1;
          nxt = stClrRd;
        end
      end
      stFin: nxt = stIdle;
      default: nxt = stIdle;
    endcase
  end

  assign outValid = (state == stPayOut);
  assign busy     = (state != stIdle);
  assign done     = (state == stFin);

  assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> (!memReq && !outValid));

  assert_out_hold_R4: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && !outReady) |=> outValid);

  assert_done_then_idle_R12: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !busy);

endmodule

// File: rtl/dma_list_walker.sv
module dma_list_walker
  import dma_list_walker_pkg::*;
#(
  parameter int ADDR_W      = 24,
  parameter int MEM_AW      = 21,
  parameter int DATA_W      = 32,
  parameter int LEN_W       = 8,
  parameter int COST_W      = 32,
  parameter int NODE_COST   = 5,
  parameter int LOOP_THRESH = 8192
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  input  logic [ADDR_W-1:0] startAddr,
  output logic              memReq,
  output logic              memWe,
  output logic [MEM_AW-3:0] memAddr,
  output logic [DATA_W-1:0] memWdata,
  input  logic              memReady,
  input  logic              memRvalid,
  input  logic [DATA_W-1:0] memRdata,
  output logic              outValid,
  output logic [DATA_W-1:0] outData,
  input  logic              outReady,
  output logic              busy,
  output logic              done,
  output logic [COST_W-1:0] costTotal
);

  walkCtl_t ctl;
  logic termNext, lenZero, markPend, haveMarks, clrDone;

  dma_list_walker_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .start(start), .memReady(memReady),
    .memRvalid(memRvalid), .outReady(outReady), .termNext(termNext),
    .lenZero(lenZero), .markPend(markPend), .haveMarks(haveMarks),
    .clrDone(clrDone), .ctl(ctl), .memReq(memReq), .memWe(memWe),
    .outValid(outValid), .busy(busy), .done(done)
  );

  dma_list_walker_dp #(
    .ADDR_W(ADDR_W), .MEM_AW(MEM_AW), .DATA_W(DATA_W), .LEN_W(LEN_W),
    .COST_W(COST_W), .NODE_COST(NODE_COST), .LOOP_THRESH(LOOP_THRESH)
  ) u_dp (
    .clk(clk), .rstN(rstN), .ctl(ctl), .startAddr(startAddr),
    .memRdata(memRdata), .memAddr(memAddr), .memWdata(memWdata),
    .outData(outData), .costTotal(costTotal), .termNext(termNext),
    .lenZero(lenZero), .markPend(markPend), .haveMarks(haveMarks),
    .clrDone(clrDone)
  );

  assert_req_hold_R11: assert property (@(posedge clk) disable iff (!rstN)
    (memReq && !memReady) |=> (memReq && $stable(memAddr) && $stable(memWe) && $stable(memWdata)));

  assert_data_hold_R4: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && !outReady) |=> $stable(outData));

  assert_cost_held_R6: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && !start) |=> $stable(costTotal));

endmodule

// File: tb/dma_list_walker_bench.sv
module dma_list_walker_bench;
  localparam int CLK_PERIOD = 10;
  localparam int THR = 4;
  localparam int WALK_LIMIT = 20000;

  logic clk = 1'b0, rstN = 1'b0, start = 1'b0;
  logic [23:0] startAddr = '0;
  logic memReq, memWe, memReady = 1'b0, memRvalid = 1'b0;
  logic [18:0] memAddr;
  logic [31:0] memWdata, memRdata = '0, outData, costTotal;
  logic outValid, outReady = 1'b0, busy, done;

  dma_list_walker #(.LOOP_THRESH(THR)) u_dma_list_walker (
    .clk(clk), .rstN(rstN), .start(start), .startAddr(startAddr),
    .memReq(memReq), .memWe(memWe), .memAddr(memAddr), .memWdata(memWdata),
    .memReady(memReady), .memRvalid(memRvalid), .memRdata(memRdata),
    .outValid(outValid), .outData(outData), .outReady(outReady),
    .busy(busy), .done(done), .costTotal(costTotal)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  logic [31:0] mem [int];
  logic [31:0] snap [int];
  logic [31:0] gotQ [$];
  logic [31:0] expQ [$];
  int expCost, expMarks, wrSet, wrClr;
  int nChecks = 0, nFails = 0, cycles = 0;

  function automatic logic [31:0] rdMem(input int i);
    return mem.exists(i) ? mem[i] : 32'h0;
  endfunction

  // memory model: read data returned the cycle after acceptance
  always @(posedge clk) begin
    memRvalid <= 1'b0;
    if (memReq && memReady) begin
      if (memWe) begin
        mem[int'(memAddr)] = memWdata;
        if (memWdata[23]) wrSet++; else wrClr++;
      end else begin
        memRdata  <= rdMem(int'(memAddr));
        memRvalid <= 1'b1;
      end
    end
    if (outValid && outReady) gotQ.push_back(outData);
  end

  always @(negedge clk) begin
    memReady <= ($urandom % 4) != 0;
    outReady <= ($urandom % 3) != 0;
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      nFails++;
      $display("FAIL watchdog: actual %0d expected %0d", cycles, 150000);
      $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
      $finish;
    end
  end

  function automatic void predict(input logic [23:0] sa);
    logic [23:0] a;
    logic [31:0] h;
    bit seen [int];
    int n, p;
    a = sa; n = 0; expCost = 0; expMarks = 0; expQ.delete();
    while (!a[23]) begin
      p = int'(a[20:2]);
      h = rdMem(p);
      if (seen.exists(p)) h[23] = 1'b1;
      if (n >= THR && !h[23]) begin seen[p] = 1'b1; expMarks++; end
      expCost += 5 + int'(h[31:24]);
      for (int k = 1; k <= int'(h[31:24]); k++) expQ.push_back(rdMem((p + k) & 32'h7ffff));
      n++;
      a = h[23:0];
    end
  endfunction

  function automatic logic [23:0] nodeAddr(input int idx);
    return {1'b0, 2'($urandom), 19'(idx), 2'($urandom)};
  endfunction

  task automatic putNode(input int idx, input int len, input logic [23:0] nxt);
    mem[idx] = {8'(len), nxt};
    for (int k = 1; k <= len; k++) mem[idx + k] = $urandom;
  endtask

  task automatic runWalk(input logic [23:0] sa, input string req, input bit poke);
    int t;
    bit same;
    predict(sa);
    snap = mem;
    gotQ.delete();
    wrSet = 0; wrClr = 0;
    @(negedge clk); start = 1'b1; startAddr = sa;
    @(negedge clk); start = 1'b0;
    if (poke) begin
      repeat (3) @(negedge clk);
      start = 1'b1; startAddr = 24'h000100;
      @(negedge clk); start = 1'b0;
    end
    t = 0;
    while (!done && t < WALK_LIMIT) begin @(negedge clk); t++; end
    chk(done === 1'b1, req, "walk completion", 32'(done), 32'h1);
    chk(costTotal == 32'(expCost), "R6", {req, " cost"}, costTotal, 32'(expCost));
    same = (gotQ.size() == expQ.size());
    if (same) foreach (gotQ[i]) if (gotQ[i] !== expQ[i]) same = 1'b0;
    chk(same, "R4", {req, " payload stream"}, 32'(gotQ.size()), 32'(expQ.size()));
    chk(wrSet == expMarks, "R7", {req, " mark writes"}, 32'(wrSet), 32'(expMarks));
    chk(wrClr == expMarks, "R9", {req, " restore writes"}, 32'(wrClr), 32'(expMarks));
    same = (mem.num() == snap.num());
    foreach (snap[k]) if (!mem.exists(k) || mem[k] !== snap[k]) same = 1'b0;
    chk(same, "R9", {req, " memory restored"}, 32'(mem.num()), 32'(snap.num()));
    @(negedge clk);
    chk(busy === 1'b0 && done === 1'b0, "R12", {req, " idle after done"}, {30'd0, busy, done}, 32'h0);
    repeat (2) @(negedge clk);
    chk(busy === 1'b0, poke ? "R10" : "R12", {req, " stays idle"}, 32'(busy), 32'h0);
    chk(costTotal == 32'(expCost), "R6", {req, " cost held"}, costTotal, 32'(expCost));
  endtask

  initial begin
    logic [23:0] ad [16];
    int n, back;
    repeat (4) @(negedge clk);
    chk(busy === 1'b0 && done === 1'b0 && memReq === 1'b0 && outValid === 1'b0,
        "R1", "reset outputs", {28'd0, busy, done, memReq, outValid}, 32'h0);
    rstN = 1'b1;
    repeat (2) @(negedge clk);
    chk(busy === 1'b0 && memReq === 1'b0, "R1", "idle after reset", {30'd0, busy, memReq}, 32'h0);

    // R2: terminator bit in the start address
    mem.delete();
    runWalk(24'h800010, "R2", 1'b0);
    // R3: single node reached through an address with ignored bits set
    mem.delete();
    putNode(10, 2, 24'h800000);
    runWalk(24'h60002B, "R3", 1'b0);
    // R5: short chain below the threshold
    mem.delete();
    ad[0] = nodeAddr(40); ad[1] = nodeAddr(80); ad[2] = nodeAddr(120);
    putNode(40, 2, ad[1]); putNode(80, 0, ad[2]); putNode(120, 3, 24'hFFFFFF);
    runWalk(ad[0], "R5", 1'b0);
    // R8: self-referencing node
    mem.delete();
    ad[0] = nodeAddr(200);
    putNode(200, 1, ad[0]);
    runWalk(ad[0], "R8", 1'b0);
    // R7: chain past the threshold ending on a terminator
    mem.delete();
    for (int i = 0; i < 8; i++) ad[i] = nodeAddr(300 + 16 * i);
    for (int i = 0; i < 8; i++) putNode(300 + 16 * i, 1, (i == 7) ? 24'h800123 : ad[i + 1]);
    runWalk(ad[0], "R7", 1'b0);
    // R10: second start while busy
    runWalk(ad[0], "R10", 1'b1);

    for (int r = 0; r < 14; r++) begin
      mem.delete();
      n = 1 + ($urandom % 10);
      for (int i = 0; i < n; i++) ad[i] = nodeAddr(1000 + 16 * i);
      back = $urandom % n;
      for (int i = 0; i < n - 1; i++) putNode(1000 + 16 * i, $urandom % 6, ad[i + 1]);
      putNode(1000 + 16 * (n - 1), $urandom % 6,
              ($urandom % 2) ? {1'b1, 23'($urandom)} : ad[back]);
      runWalk(ad[0], "R8", (r % 3) == 0 && n > 2);
    end

    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end
endmodule